// File: doc/BRIEF.md
# Sprite Table Page-Copy DMA

This block copies one fixed-size block of bytes from a page of memory into the sprite attribute region. A processor starts it by writing a page number to a single memory-mapped trigger register. The engine forms the source start address as that page number times 256, so every source block begins on a 256-byte boundary. It then moves 160 bytes, one after another, into the region that begins at 0xFE00. For the whole transfer it raises a busy flag so that surrounding logic can tell when the sprite table is being rewritten.

The pace is fixed. Each byte takes a slot of four clocks. The engine reads on the first clock of the slot, captures the returned byte on the second, writes it on the third and stays quiet on the fourth. A transfer therefore holds busy for exactly 640 clocks. Writing the trigger register again while a transfer is in flight abandons the old transfer. The engine latches the new page and starts over from byte 0 with a full 640-clock window.

The memory side is a single synchronous byte port. A read strobe presents an address, and the addressed byte must appear on the read-data input on the next clock.

Top module: `spr_page_dma`

## Requirements
- R1: While reset is asserted, and on the first clock after it, busy is low and neither the read strobe nor the write strobe is high. A reset during a transfer abandons it.
- R2: A clock with `cfg_we` high and `cfg_addr` equal to 0xFF46 starts a transfer using page `cfg_wdata`. Busy is high on the next clock.
- R3: A register write to any other address, or a clock with `cfg_addr` at 0xFF46 but `cfg_we` low, changes neither busy nor the memory strobes. This holds whether the engine is idle or busy.
- R4: After a start with no restart, busy stays high for exactly 640 consecutive clocks and then falls.
- R5: Counting busy clocks from 0, on clock 4k (k = 0..159) the read strobe is high with `mem_addr` equal to page*256 + k. The read strobe is low on every other clock.
- R6: On busy clock 4k+2, the write strobe is high with `mem_addr` equal to 0xFE00 + k. `mem_wdata` carries the byte returned for the read of byte k. The write strobe is low on every other clock.
- R7: An uninterrupted transfer makes exactly 160 reads and 160 writes, and it writes only within 0xFE00 to 0xFE9F. When it ends, that region holds the 160 source bytes in order.
- R8: A trigger write during a transfer (including on its last busy clock) latches the new page, restarts the byte count at 0 and reloads the 640-clock window. The region then ends up holding the new page's bytes.
- R9: The read and write strobes are never high together, and both are low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Processor register write strobe |
| cfg_addr | input | 16 | Processor register write address |
| cfg_wdata | input | 8 | Processor write data (source page number) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address for the read or the write |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the clock after a read strobe |
| busy | output | 1 | High while a transfer is in progress |

## Verification
The hardest case to reach is a restart that lands at a chosen point inside a running transfer. The cases covered are each of the four clocks of a byte slot and the very last busy clock, where the old window is about to close in the same cycle. The bench reaches these points by counting falling edges after the first trigger before it issues the second. The offsets cover the slot phases around byte 75, back-to-back triggers, and clock 640. A behavioural model then predicts every strobe, address and data byte on every clock. A final readback of the destination region shows that only the new page's bytes remain.

// File: rtl/spr_dma_pkg.sv
// Shared constants and types for the sprite-table page-copy DMA.
// Assumes a 16-bit byte-addressed memory space with an 8-bit data path.
package spr_dma_pkg;

    localparam int unsigned SPR_ADDR_W = 16;
    localparam int unsigned SPR_DATA_W = 8;

    typedef logic [SPR_ADDR_W-1:0] spr_addr_t;
    typedef logic [SPR_DATA_W-1:0] spr_byte_t;

    // One clock's request on the memory master port.
    typedef struct packed {
        logic      rd;
        logic      wr;
        spr_addr_t addr;
        spr_byte_t wdata;
    } spr_mem_cmd_t;

endpackage

// File: rtl/spr_dma_trigger.sv
// Decodes a processor write to the trigger register and latches the page.
// Assumes the register port presents a full byte address and one byte per
// write. A start pulse is combinational in the write cycle.
module spr_dma_trigger
    import spr_dma_pkg::*;
#(
    parameter spr_addr_t TRIG_ADDR = 16'hFF46
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  spr_addr_t cfg_addr,
    input  spr_byte_t cfg_wdata,
    output logic      start,
    output spr_byte_t page
);

    // Recognise a write that hits the trigger register.
    always_comb begin
        start = cfg_we && (cfg_addr == TRIG_ADDR);
    end

    // Hold the most recently requested source page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
        end else if (start) begin
            page <= cfg_wdata;
        end
    end

endmodule

// File: rtl/spr_dma_timer.sv
// Fixed-length transfer window: loads TOTAL_CLKS on start and counts down.
// Assumes a start may arrive at any time, including while counting.
module spr_dma_timer #(
    parameter int unsigned TOTAL_CLKS = 640,
    localparam int unsigned CNT_W     = $clog2(TOTAL_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [CNT_W-1:0] remain;

    // Reload on every start, otherwise run down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(TOTAL_CLKS);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // The window is open while any clocks remain.
    always_comb begin
        busy = (remain != '0);
    end

endmodule

// File: rtl/spr_dma_mover.sv
// Byte sequencer: walks a byte index through fixed-length clock slots,
// reading on the first clock of a slot and writing later in the same slot.
// Assumes the memory returns read data one clock after the read strobe and
// that CLKS_PER_BYTE leaves room for the chosen write clock.
// REG_READ_DATA=1 captures the byte and writes on slot clock 2.
// REG_READ_DATA=0 writes the returned byte straight through on slot clock 1.
module spr_dma_mover
    import spr_dma_pkg::*;
#(
    parameter int unsigned BLOCK_LEN     = 160,
    parameter int unsigned CLKS_PER_BYTE = 4,
    parameter spr_addr_t   DST_BASE      = 16'hFE00,
    parameter bit          REG_READ_DATA = 1'b1,
    localparam int unsigned IDX_W        = $clog2(BLOCK_LEN),
    localparam int unsigned PH_W         = $clog2(CLKS_PER_BYTE),
    localparam int unsigned WRITE_SLOT   = REG_READ_DATA ? 2 : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         busy,
    input  spr_byte_t    page,
    input  spr_byte_t    mem_rdata,
    output spr_mem_cmd_t cmd
);

    logic [PH_W-1:0]  phase;
    logic [IDX_W-1:0] idx;
    spr_addr_t        src_addr;
    spr_addr_t        dst_addr;
    spr_byte_t        wr_byte;
    logic             do_rd;
    logic             do_wr;

    // Advance the slot phase and the byte index; a start rewinds both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            idx   <= '0;
        end else if (start) begin
            phase <= '0;
            idx   <= '0;
        end else if (busy) begin
            if (phase == PH_W'(CLKS_PER_BYTE - 1)) begin
                phase <= '0;
                if (idx != IDX_W'(BLOCK_LEN - 1)) begin
                    idx <= idx + 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Choose how the read byte reaches the write data path.
    generate
        if (REG_READ_DATA) begin : g_captured
            spr_byte_t hold;

            // Capture the byte returned for this slot's read.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold <= '0;
                end else if (busy && (phase == PH_W'(1))) begin
                    hold <= mem_rdata;
                end
            end

            // Write data comes from the capture register.
            always_comb begin
                wr_byte = hold;
            end
        end else begin : g_through
            // Write data is the read data as it arrives.
            always_comb begin
                wr_byte = mem_rdata;
            end
        end
    endgenerate

    // Form the source and destination addresses for the current byte.
    always_comb begin
        src_addr = {page, 8'h00} + SPR_ADDR_W'(idx);
        dst_addr = DST_BASE + SPR_ADDR_W'(idx);
    end

    // Strobe decode for the slot clock in progress.
    always_comb begin
        do_rd = busy && (phase == '0);
        do_wr = busy && (phase == PH_W'(WRITE_SLOT));
    end

    // Present a single request to the memory port.
    always_comb begin
        cmd.rd    = do_rd;
        cmd.wr    = do_wr;
        cmd.addr  = do_wr ? dst_addr : src_addr;
        cmd.wdata = wr_byte;
    end

endmodule

// File: rtl/spr_page_dma.sv
// Top level of the sprite-table page-copy DMA.
// A write of a page number to the trigger register copies BLOCK_LEN bytes
// from page*256 into DST_BASE, one byte per CLKS_PER_BYTE clocks, with busy
// held for BLOCK_LEN*CLKS_PER_BYTE clocks. Assumes a synchronous byte memory
// with one clock of read latency and no contention on the memory port.
module spr_page_dma
    import spr_dma_pkg::*;
#(
    parameter spr_addr_t   TRIG_ADDR     = 16'hFF46,
    parameter spr_addr_t   DST_BASE      = 16'hFE00,
    parameter int unsigned BLOCK_LEN     = 160,
    parameter int unsigned CLKS_PER_BYTE = 4,
    parameter bit          REG_READ_DATA = 1'b1,
    localparam int unsigned TOTAL_CLKS   = BLOCK_LEN * CLKS_PER_BYTE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic        mem_rd_en,
    output logic        mem_wr_en,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy
);

    logic         start;
    spr_byte_t    page;
    logic         busy_w;
    spr_mem_cmd_t cmd;

    spr_dma_trigger #(
        .TRIG_ADDR (TRIG_ADDR)
    ) u_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .start     (start),
        .page      (page)
    );

    spr_dma_timer #(
        .TOTAL_CLKS (TOTAL_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy_w)
    );

    spr_dma_mover #(
        .BLOCK_LEN     (BLOCK_LEN),
        .CLKS_PER_BYTE (CLKS_PER_BYTE),
        .DST_BASE      (DST_BASE),
        .REG_READ_DATA (REG_READ_DATA)
    ) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy_w),
        .page      (page),
        .mem_rdata (mem_rdata),
        .cmd       (cmd)
    );

    // Drive the ports from the sequencer request and the window flag.
    always_comb begin
        mem_rd_en = cmd.rd;
        mem_wr_en = cmd.wr;
        mem_addr  = cmd.addr;
        mem_wdata = cmd.wdata;
        busy      = busy_w;
    end

endmodule

// File: rtl/spr_dma_chk.sv
// Protocol checker for spr_page_dma, attached with bind. It observes only
// top-level ports and keeps its own run-length counter for the busy window.
module spr_dma_chk #(
    parameter logic [15:0] TRIG_ADDR     = 16'hFF46,
    parameter logic [15:0] DST_BASE      = 16'hFE00,
    parameter int unsigned BLOCK_LEN     = 160,
    parameter int unsigned CLKS_PER_BYTE = 4,
    localparam int unsigned TOTAL_CLKS   = BLOCK_LEN * CLKS_PER_BYTE,
    localparam int unsigned RUN_W        = $clog2(TOTAL_CLKS + 2)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [15:0] cfg_addr,
    input logic        busy,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [15:0] mem_addr
);

    logic             trig;
    logic [RUN_W-1:0] run_len;

    // Trigger as seen at the register port.
    always_comb begin
        trig = cfg_we && (cfg_addr == TRIG_ADDR);
    end

    // Count busy clocks since the latest trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (trig) begin
            run_len <= RUN_W'(1);
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R9
    no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy);

    // R4
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len >= RUN_W'(1) && run_len <= RUN_W'(TOTAL_CLKS)));

    // R4
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len == RUN_W'(TOTAL_CLKS) && !trig) |=> !busy);

    // R5
    read_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_addr[7:0]) < BLOCK_LEN));

    // R7
    write_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr >= DST_BASE && int'(mem_addr - DST_BASE) < BLOCK_LEN));

    // R6
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2));

endmodule

bind spr_page_dma spr_dma_chk #(
    .TRIG_ADDR     (TRIG_ADDR),
    .DST_BASE      (DST_BASE),
    .BLOCK_LEN     (BLOCK_LEN),
    .CLKS_PER_BYTE (CLKS_PER_BYTE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr)
);

// File: tb/tb_spr_page_dma.sv
// Bench for spr_page_dma: behavioural model compared on every clock,
// a synchronous byte memory, and directed scenarios.
module tb_spr_page_dma;

    localparam int TRIG   = 16'hFF46;
    localparam int DST    = 16'hFE00;
    localparam int LEN    = 160;
    localparam int WINDOW = 640;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    spr_page_dma dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy)
    );

    always #5 clk = ~clk;

    // Source content is a function of the address.
    function automatic logic [7:0] src_byte(input int a);
        logic [15:0] w;
        w = a[15:0];
        return w[7:0] ^ {w[11:8], w[15:12]} ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
        end
    endtask

    // Memory model with statistics.
    logic [7:0] dst_mem [LEN];
    int  rd_cnt, wr_cnt, stray_cnt;
    bit  clr_stats = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr_stats) begin
            rd_cnt <= 0; wr_cnt <= 0; stray_cnt <= 0;
            for (int i = 0; i < LEN; i++) dst_mem[i] <= 8'hEE;
        end else begin
            if (mem_rd_en) begin
                mem_rdata <= src_byte(int'(mem_addr));
                rd_cnt    <= rd_cnt + 1;
            end
            if (mem_wr_en) begin
                if (int'(mem_addr) >= DST && int'(mem_addr) < DST + LEN) begin
                    dst_mem[int'(mem_addr) - DST] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    stray_cnt <= stray_cnt + 1;
                end
            end
        end
    end

    // Reference model: remaining window and latched page.
    int ref_cnt = 0;
    int ref_page = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt  <= 0;
            ref_page <= 0;
        end else if (cfg_we && int'(cfg_addr) == TRIG) begin
            ref_cnt  <= WINDOW;
            ref_page <= int'(cfg_wdata);
        end else if (ref_cnt > 0) begin
            ref_cnt <= ref_cnt - 1;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        bit exp_busy, exp_rd, exp_wr;
        int el, k;
        exp_busy = (ref_cnt > 0);
        el = WINDOW - ref_cnt;
        k  = el / 4;
        exp_rd = exp_busy && (el % 4 == 0);
        exp_wr = exp_busy && (el % 4 == 2);
        chk(busy == exp_busy, "R4 busy", int'(busy), int'(exp_busy));
        chk(mem_rd_en == exp_rd, "R5 read strobe", int'(mem_rd_en), int'(exp_rd));
        chk(mem_wr_en == exp_wr, "R6 write strobe", int'(mem_wr_en), int'(exp_wr));
        if (!exp_busy)
            chk(!mem_rd_en && !mem_wr_en, "R9 idle strobes", int'({mem_rd_en, mem_wr_en}), 0);
        if (exp_rd && mem_rd_en)
            chk(int'(mem_addr) == ref_page * 256 + k, "R5 read address", int'(mem_addr), ref_page * 256 + k);
        if (exp_wr && mem_wr_en) begin
            chk(int'(mem_addr) == DST + k, "R6 write address", int'(mem_addr), DST + k);
            chk(mem_wdata == src_byte(ref_page * 256 + k), "R6 write data",
                int'(mem_wdata), int'(src_byte(ref_page * 256 + k)));
        end
    end

    task automatic clear_stats();
        @(negedge clk); clr_stats = 1'b1;
        @(negedge clk); clr_stats = 1'b0;
    endtask

    // Drive one register write for one clock; returns on the next falling edge.
    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[15:0]; cfg_wdata = d[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Count busy clocks from the current falling edge until busy drops.
    task automatic run_to_idle(output int n);
        n = 0;
        while (busy && n < 2 * WINDOW) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_region(input int page, input string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int i = 0; i < LEN; i++) begin
            if (dst_mem[i] != src_byte(page * 256 + i)) begin
                if (bad == 0) begin first_act = int'(dst_mem[i]); first_exp = int'(src_byte(page * 256 + i)); end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic plain_transfer(input int page);
        int n;
        clear_stats();
        reg_write(TRIG, page);
        chk(busy == 1'b1, "R2 busy after trigger", int'(busy), 1);
        run_to_idle(n);
        chk(n == WINDOW, "R4 window length", n, WINDOW);
        chk(rd_cnt == LEN, "R7 read count", rd_cnt, LEN);
        chk(wr_cnt == LEN, "R7 write count", wr_cnt, LEN);
        chk(stray_cnt == 0, "R7 stray writes", stray_cnt, 0);
        check_region(page, "R7 region content");
    endtask

    task automatic restart_at(input int off, input int p0, input int p1);
        int n;
        clear_stats();
        reg_write(TRIG, p0);
        repeat (off - 2) @(negedge clk);
        reg_write(TRIG, p1);
        chk(busy == 1'b1, "R8 busy after restart", int'(busy), 1);
        run_to_idle(n);
        chk(n == WINDOW, "R8 window reload", n, WINDOW);
        chk(stray_cnt == 0, "R8 stray writes", stray_cnt, 0);
        check_region(p1, "R8 region holds new page");
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(!mem_rd_en && !mem_wr_en, "R1 strobes in reset", int'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

        // R2, R4, R5, R6, R7: ordinary transfers, including boundary pages
        plain_transfer(8'h12);
        plain_transfer(8'h00);
        plain_transfer(8'hFF);

        // R3: non-trigger writes while idle
        reg_write(16'hFF47, 8'h33);
        chk(busy == 1'b0, "R3 other address idle", int'(busy), 0);
        reg_write(16'h0046, 8'h33);
        chk(busy == 1'b0, "R3 low-page alias idle", int'(busy), 0);
        @(negedge clk);
        cfg_addr = TRIG[15:0]; cfg_wdata = 8'h44; cfg_we = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && !mem_rd_en, "R3 address without strobe", int'(busy), 0);

        // R3: non-trigger writes while busy do not disturb the window
        clear_stats();
        reg_write(TRIG, 8'h5C);
        repeat (50) @(negedge clk);
        reg_write(16'hFF45, 8'h99);
        reg_write(16'hFE46, 8'h99);
        run_to_idle(n);
        chk(n == WINDOW - 54, "R3 window unchanged by other writes", n, WINDOW - 54);
        check_region(8'h5C, "R3 region keeps first page");

        // R8: restarts on every slot phase, back to back, and on the last busy clock
        restart_at(2,   8'h20, 8'h34);
        restart_at(301, 8'h21, 8'h35);
        restart_at(302, 8'h22, 8'h36);
        restart_at(303, 8'h23, 8'h37);
        restart_at(304, 8'h24, 8'h38);
        restart_at(640, 8'h25, 8'h39);

        // R1: reset during a transfer abandons it
        reg_write(TRIG, 8'h40);
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after mid-transfer reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && !mem_rd_en && !mem_wr_en, "R1 stays idle", int'(busy), 0);

        // R7: one more clean transfer after the reset
        plain_transfer(8'h81);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule